// File: doc/BRIEF.md
# Interlaced Video Timing Generator

This block produces horizontal sync, vertical sync, composite sync, data enable and a field flag for a raster display. It runs in progressive or interlaced mode. Pixel and line positions count from the top-left pixel of the visible area, so position (0,0) is the first visible pixel of a field. The timing is set by configuration inputs: the visible size, the horizontal sync window, the horizontal total, and two per-field sets. Each per-field set holds a vertical total, the first and last vertical sync lines, and the pixel at which vertical sync changes level.

In interlaced mode the generator alternates between the odd-field set and the even-field set. The odd field normally has one more line, and it moves its vertical sync edge to the middle of the line. In progressive mode only the even-field set is used. All timing configuration is copied into shadow registers at each field boundary, so no field ever runs with a mix of old and new values.

Each sync output has its own polarity inversion. A blank input replaces the pixel bus with a fixed blank colour, but only when the output mode is 24-bit RGB. In the other modes the bus is left as it is.

Top module: `itg_top`

## Requirements
- R1: While reset is asserted, every output is low, including the pixel bus.
- R2: Each line lasts h_total pixel clocks and each field lasts v_total lines of its own set. Outputs appear one clock after the position they describe. Data enable is high only when the pixel position is below h_active and the line position is below v_active.
- R3: Horizontal sync is active when the pixel position is at or above hs_start and below hs_end.
- R4: Vertical sync turns active at pixel vs_pixel of line vs_start and inactive at pixel vs_pixel of line vs_end. All four values come from the set of the current field.
- R5: In interlaced mode the first field after reset uses the odd set (slot 0) and field_o is low. The fields then alternate at every field start, and field_o is high during fields that use the even set (slot 1). A field lasts h_total × v_total cycles of its own set.
- R6: In progressive mode every field uses the even set and field_o stays low.
- R7: Configuration changes made in the middle of a field have no effect until the next field starts. The interlace mode bit is included.
- R8: When inv_hsync, inv_vsync or inv_csync is 1, the matching sync output is active low. Otherwise it is active high. Each bit acts on its own output only, with one clock of latency.
- R9: Composite sync is active when horizontal sync or vertical sync is active.
- R10: When blank is 1 and out_mode is 0 (24-bit RGB), pix_o is the blank colour one clock later. In every other case pix_o is pix_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_active | input | 12 | Visible pixels per line |
| cfg_hs_start | input | 12 | Pixel where horizontal sync starts |
| cfg_hs_end | input | 12 | Pixel where horizontal sync ends (exclusive) |
| cfg_h_total | input | 12 | Pixel clocks per line |
| cfg_v_active | input | 12 | Visible lines per field |
| cfg_odd_v_total | input | 12 | Odd-field line count |
| cfg_odd_vs_start | input | 12 | Odd-field vertical sync first line |
| cfg_odd_vs_end | input | 12 | Odd-field vertical sync release line |
| cfg_odd_vs_pixel | input | 12 | Odd-field pixel of vertical sync edges |
| cfg_even_v_total | input | 12 | Even/progressive line count |
| cfg_even_vs_start | input | 12 | Even-field vertical sync first line |
| cfg_even_vs_end | input | 12 | Even-field vertical sync release line |
| cfg_even_vs_pixel | input | 12 | Even-field pixel of vertical sync edges |
| cfg_interlace | input | 1 | 1 selects interlaced operation |
| inv_hsync | input | 1 | Make horizontal sync active low |
| inv_vsync | input | 1 | Make vertical sync active low |
| inv_csync | input | 1 | Make composite sync active low |
| blank | input | 1 | Request blank colour on the pixel bus |
| out_mode | input | 2 | Output bus mode, 0 = 24-bit RGB |
| pix_i | input | 24 | Incoming pixel data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Field flag, high in even-set fields |
| pix_o | output | 24 | Pixel bus |

## Verification
The bench targets the field boundary, since that is where most faults would show. A design that selects the wrong slot gives odd fields of the even length, or places the vertical sync edge at the wrong pixel. A design that copies the configuration at the wrong time lets a mid-field width change shorten data enable within the same field. A design that leaves the field flag toggling after a switch to progressive mode would also be caught. Randomly varied polarity, blank and output mode expose a blank that overrides the bus in non-RGB modes, and inversions that leak between sync outputs.

// File: rtl/itg_pkg.sv
package itg_pkg;
  parameter int unsigned ITG_CW = 12;

  localparam int unsigned ITG_NSLOT     = 2;
  localparam int unsigned ITG_SLOT_ODD  = 0;
  localparam int unsigned ITG_SLOT_EVEN = 1;

  typedef logic [ITG_CW-1:0] itg_cnt_t;

  typedef struct packed {
    itg_cnt_t v_total;
    itg_cnt_t vs_start;
    itg_cnt_t vs_end;
    itg_cnt_t vs_pixel;
  } itg_field_t;

  typedef struct packed {
    itg_cnt_t h_active;
    itg_cnt_t hs_start;
    itg_cnt_t hs_end;
    itg_cnt_t h_total;
    itg_cnt_t v_active;
    logic     interlace;
  } itg_line_t;

  typedef enum logic [1:0] {
    OMODE_RGB24  = 2'd0,
    OMODE_RGB18  = 2'd1,
    OMODE_RGB16  = 2'd2,
    OMODE_SERIAL = 2'd3
  } itg_omode_e;
endpackage

// File: rtl/itg_shadow.sv
module itg_shadow
  import itg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  itg_line_t                   line_i,
  input  itg_field_t [ITG_NSLOT-1:0]  fld_i,
  output itg_line_t                   line_o,
  output itg_field_t [ITG_NSLOT-1:0]  fld_o
);
  itg_line_t line_q;
  itg_line_t line_d;

  always_comb begin
    line_d = line_q;
    if (load_i) line_d = line_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign line_o = line_q;

  generate
    for (genvar g = 0; g < ITG_NSLOT; g++) begin : g_slot
      itg_field_t slot_q;
      itg_field_t slot_d;

      always_comb begin
        slot_d = slot_q;
        if (load_i) slot_d = fld_i[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
      end

      assign fld_o[g] = slot_q;

      // R7: a field set only changes on a field boundary
      assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(fld_o[g]))
        else $error("field set changed without a boundary");
    end
  endgenerate

  // R7: line timing only changes on a field boundary
  assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(line_o))
    else $error("line timing changed without a boundary");
endmodule

// File: rtl/itg_counter.sv
module itg_counter
  import itg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  itg_cnt_t h_total_i,
  input  itg_cnt_t v_total_i,
  input  logic     il_cfg_i,
  input  logic     il_shadow_i,
  output logic     run_o,
  output logic     load_o,
  output itg_cnt_t hpos_o,
  output itg_cnt_t vpos_o,
  output logic     field_o
);
  logic     run_q, run_d;
  itg_cnt_t h_q, h_d;
  itg_cnt_t v_q, v_d;
  logic     fld_q, fld_d;
  logic     h_last, v_last, wrap;

  always_comb begin
    h_last = (h_q >= (h_total_i - itg_cnt_t'(1)));
    v_last = (v_q >= (v_total_i - itg_cnt_t'(1)));
    wrap   = run_q & h_last & v_last;
    run_d  = run_q;
    h_d    = h_q;
    v_d    = v_q;
    if (!run_q) begin
      run_d = 1'b1;
      h_d   = '0;
      v_d   = '0;
    end else if (h_last) begin
      h_d = '0;
      v_d = v_last ? '0 : (v_q + itg_cnt_t'(1));
    end else begin
      h_d = h_q + itg_cnt_t'(1);
    end
    fld_d = wrap ? (il_cfg_i & ~fld_q) : fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      h_q   <= '0;
      v_q   <= '0;
      fld_q <= 1'b0;
    end else begin
      run_q <= run_d;
      h_q   <= h_d;
      v_q   <= v_d;
      fld_q <= fld_d;
    end
  end

  assign run_o   = run_q;
  assign load_o  = ~run_q | wrap;
  assign hpos_o  = h_q;
  assign vpos_o  = v_q;
  assign field_o = fld_q;

  // R2: pixel position stays inside the programmed line
  assert_h_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && h_total_i != '0) |-> (h_q < h_total_i))
    else $error("pixel position beyond line total");

  // R5: the field only changes right after a field wrap
  assert_field_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> $stable(fld_q))
    else $error("field changed inside a field");

  // R6: progressive timing never runs in the second field
  assert_prog_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !il_shadow_i |-> !fld_q)
    else $error("field set while progressive");
endmodule

// File: rtl/itg_decode.sv
module itg_decode
  import itg_pkg::*;
#(
  parameter int unsigned    PW          = 24,
  parameter logic [PW-1:0]  BLANK_COLOR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  itg_cnt_t      hpos_i,
  input  itg_cnt_t      vpos_i,
  input  logic          field_i,
  input  itg_cnt_t      h_active_i,
  input  itg_cnt_t      hs_start_i,
  input  itg_cnt_t      hs_end_i,
  input  itg_cnt_t      v_active_i,
  input  itg_cnt_t      vs_start_i,
  input  itg_cnt_t      vs_end_i,
  input  itg_cnt_t      vs_pixel_i,
  input  logic          inv_hs_i,
  input  logic          inv_vs_i,
  input  logic          inv_cs_i,
  input  logic          blank_i,
  input  logic [1:0]    out_mode_i,
  input  logic [PW-1:0] pix_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o,
  output logic          de_o,
  output logic          field_o,
  output logic [PW-1:0] pix_o
);
  logic          de_n, hs_n, vs_n, cs_n, blank_rgb;
  logic [PW-1:0] pix_n;
  logic          vs_st_q;
  logic          hs_q, vs_q, cs_q, de_q, fld_q;
  logic [PW-1:0] pix_q;

  always_comb begin
    de_n = run_i && (hpos_i < h_active_i) && (vpos_i < v_active_i);
    hs_n = run_i && (hpos_i >= hs_start_i) && (hpos_i < hs_end_i);
    vs_n = vs_st_q;
    if (!run_i) begin
      vs_n = 1'b0;
    end else if (hpos_i == vs_pixel_i) begin
      if (vpos_i == vs_start_i)    vs_n = 1'b1;
      else if (vpos_i == vs_end_i) vs_n = 1'b0;
    end
    cs_n      = hs_n | vs_n;
    blank_rgb = blank_i && (out_mode_i == OMODE_RGB24);
    pix_n     = blank_rgb ? BLANK_COLOR : pix_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_st_q <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      cs_q    <= 1'b0;
      de_q    <= 1'b0;
      fld_q   <= 1'b0;
      pix_q   <= '0;
    end else begin
      vs_st_q <= vs_n;
      hs_q    <= hs_n ^ inv_hs_i;
      vs_q    <= vs_n ^ inv_vs_i;
      cs_q    <= cs_n ^ inv_cs_i;
      de_q    <= de_n;
      fld_q   <= run_i & field_i;
      pix_q   <= pix_n;
    end
  end

  assign hsync_o = hs_q;
  assign vsync_o = vs_q;
  assign csync_o = cs_q;
  assign de_o    = de_q;
  assign field_o = fld_q;
  assign pix_o   = pix_q;

  // R1: nothing is shown before the first field starts
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> (!de_o && !field_o))
    else $error("output active before first field");

  // R9: composite sync follows the active levels of both syncs
  assert_csync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_i) |-> ((csync_o ^ $past(inv_cs_i)) ==
                      ((hsync_o ^ $past(inv_hs_i)) | (vsync_o ^ $past(inv_vs_i)))))
    else $error("composite sync mismatch");

  // R10: blank in 24-bit RGB mode forces the blank colour
  assert_blank_rgb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && $past(blank_i) && ($past(out_mode_i) == OMODE_RGB24))
      |-> (pix_o == BLANK_COLOR))
    else $error("blank colour missing");

  // R10: otherwise the bus passes data through
  assert_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && !($past(blank_i) && ($past(out_mode_i) == OMODE_RGB24)))
      |-> (pix_o == $past(pix_i)))
    else $error("pixel data not passed");
endmodule

// File: rtl/itg_top.sv
module itg_top
  import itg_pkg::*;
#(
  parameter int unsigned   PW          = 24,
  parameter logic [PW-1:0] BLANK_COLOR = 24'h101010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ITG_CW-1:0] cfg_h_active,
  input  logic [ITG_CW-1:0] cfg_hs_start,
  input  logic [ITG_CW-1:0] cfg_hs_end,
  input  logic [ITG_CW-1:0] cfg_h_total,
  input  logic [ITG_CW-1:0] cfg_v_active,
  input  logic [ITG_CW-1:0] cfg_odd_v_total,
  input  logic [ITG_CW-1:0] cfg_odd_vs_start,
  input  logic [ITG_CW-1:0] cfg_odd_vs_end,
  input  logic [ITG_CW-1:0] cfg_odd_vs_pixel,
  input  logic [ITG_CW-1:0] cfg_even_v_total,
  input  logic [ITG_CW-1:0] cfg_even_vs_start,
  input  logic [ITG_CW-1:0] cfg_even_vs_end,
  input  logic [ITG_CW-1:0] cfg_even_vs_pixel,
  input  logic              cfg_interlace,
  input  logic              inv_hsync,
  input  logic              inv_vsync,
  input  logic              inv_csync,
  input  logic              blank,
  input  logic [1:0]        out_mode,
  input  logic [PW-1:0]     pix_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              csync_o,
  output logic              de_o,
  output logic              field_o,
  output logic [PW-1:0]     pix_o
);
  itg_line_t                  cfg_line, sh_line;
  itg_field_t [ITG_NSLOT-1:0] cfg_fld, sh_fld;
  itg_field_t                 cur_fld;
  logic                       run, load, field, use_odd;
  itg_cnt_t                   hpos, vpos;

  always_comb begin
    cfg_line.h_active  = cfg_h_active;
    cfg_line.hs_start  = cfg_hs_start;
    cfg_line.hs_end    = cfg_hs_end;
    cfg_line.h_total   = cfg_h_total;
    cfg_line.v_active  = cfg_v_active;
    cfg_line.interlace = cfg_interlace;
    cfg_fld[ITG_SLOT_ODD].v_total   = cfg_odd_v_total;
    cfg_fld[ITG_SLOT_ODD].vs_start  = cfg_odd_vs_start;
    cfg_fld[ITG_SLOT_ODD].vs_end    = cfg_odd_vs_end;
    cfg_fld[ITG_SLOT_ODD].vs_pixel  = cfg_odd_vs_pixel;
    cfg_fld[ITG_SLOT_EVEN].v_total  = cfg_even_v_total;
    cfg_fld[ITG_SLOT_EVEN].vs_start = cfg_even_vs_start;
    cfg_fld[ITG_SLOT_EVEN].vs_end   = cfg_even_vs_end;
    cfg_fld[ITG_SLOT_EVEN].vs_pixel = cfg_even_vs_pixel;
  end

  itg_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .line_i (cfg_line),
    .fld_i  (cfg_fld),
    .line_o (sh_line),
    .fld_o  (sh_fld)
  );

  assign use_odd = sh_line.interlace & ~field;
  assign cur_fld = use_odd ? sh_fld[ITG_SLOT_ODD] : sh_fld[ITG_SLOT_EVEN];

  itg_counter u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_total_i   (sh_line.h_total),
    .v_total_i   (cur_fld.v_total),
    .il_cfg_i    (cfg_interlace),
    .il_shadow_i (sh_line.interlace),
    .run_o       (run),
    .load_o      (load),
    .hpos_o      (hpos),
    .vpos_o      (vpos),
    .field_o     (field)
  );

  itg_decode #(
    .PW          (PW),
    .BLANK_COLOR (BLANK_COLOR)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .hpos_i     (hpos),
    .vpos_i     (vpos),
    .field_i    (field),
    .h_active_i (sh_line.h_active),
    .hs_start_i (sh_line.hs_start),
    .hs_end_i   (sh_line.hs_end),
    .v_active_i (sh_line.v_active),
    .vs_start_i (cur_fld.vs_start),
    .vs_end_i   (cur_fld.vs_end),
    .vs_pixel_i (cur_fld.vs_pixel),
    .inv_hs_i   (inv_hsync),
    .inv_vs_i   (inv_vsync),
    .inv_cs_i   (inv_csync),
    .blank_i    (blank),
    .out_mode_i (out_mode),
    .pix_i      (pix_i),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .csync_o    (csync_o),
    .de_o       (de_o),
    .field_o    (field_o),
    .pix_o      (pix_o)
  );
endmodule

// File: tb/test_itg_top.sv
module test_itg_top;
  import itg_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          PW         = 24;
  localparam logic [23:0] BLANK      = 24'h101010;

  logic              clk;
  logic              rst_n;
  logic [ITG_CW-1:0] cfg_h_active, cfg_hs_start, cfg_hs_end, cfg_h_total, cfg_v_active;
  logic [ITG_CW-1:0] cfg_odd_v_total, cfg_odd_vs_start, cfg_odd_vs_end, cfg_odd_vs_pixel;
  logic [ITG_CW-1:0] cfg_even_v_total, cfg_even_vs_start, cfg_even_vs_end, cfg_even_vs_pixel;
  logic              cfg_interlace, inv_hsync, inv_vsync, inv_csync, blank;
  logic [1:0]        out_mode;
  logic [PW-1:0]     pix_i;
  logic              hsync_o, vsync_o, csync_o, de_o, field_o;
  logic [PW-1:0]     pix_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural model state
  int m_run, m_h, m_v, m_fld, m_vs;
  int s_ha, s_hss, s_hse, s_ht, s_va, s_il;
  int s_vt[2], s_vss[2], s_vse[2], s_vsp[2];

  itg_top #(.PW(PW), .BLANK_COLOR(BLANK)) i_itg_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_active(cfg_h_active), .cfg_hs_start(cfg_hs_start), .cfg_hs_end(cfg_hs_end),
    .cfg_h_total(cfg_h_total), .cfg_v_active(cfg_v_active),
    .cfg_odd_v_total(cfg_odd_v_total), .cfg_odd_vs_start(cfg_odd_vs_start),
    .cfg_odd_vs_end(cfg_odd_vs_end), .cfg_odd_vs_pixel(cfg_odd_vs_pixel),
    .cfg_even_v_total(cfg_even_v_total), .cfg_even_vs_start(cfg_even_vs_start),
    .cfg_even_vs_end(cfg_even_vs_end), .cfg_even_vs_pixel(cfg_even_vs_pixel),
    .cfg_interlace(cfg_interlace), .inv_hsync(inv_hsync), .inv_vsync(inv_vsync),
    .inv_csync(inv_csync), .blank(blank), .out_mode(out_mode), .pix_i(pix_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o), .de_o(de_o),
    .field_o(field_o), .pix_o(pix_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_shadow();
    s_ha = int'(cfg_h_active);  s_hss = int'(cfg_hs_start); s_hse = int'(cfg_hs_end);
    s_ht = int'(cfg_h_total);   s_va  = int'(cfg_v_active); s_il  = int'(cfg_interlace);
    s_vt[0]  = int'(cfg_odd_v_total);   s_vss[0] = int'(cfg_odd_vs_start);
    s_vse[0] = int'(cfg_odd_vs_end);    s_vsp[0] = int'(cfg_odd_vs_pixel);
    s_vt[1]  = int'(cfg_even_v_total);  s_vss[1] = int'(cfg_even_vs_start);
    s_vse[1] = int'(cfg_even_vs_end);   s_vsp[1] = int'(cfg_even_vs_pixel);
  endtask

  task automatic model_reset();
    m_run = 0; m_h = 0; m_v = 0; m_fld = 0; m_vs = 0;
  endtask

  // One clock: expected outputs from model and inputs, advance the model, compare.
  task automatic tick();
    int slot, e_de, e_hs, vs_n, e_cs, e_pix, e_fld;
    slot = (s_il != 0 && m_fld == 0) ? 0 : 1;
    if (m_run != 0) begin
      e_de = (m_h < s_ha && m_v < s_va) ? 1 : 0;
      e_hs = (m_h >= s_hss && m_h < s_hse) ? 1 : 0;
      vs_n = m_vs;
      if (m_h == s_vsp[slot] && m_v == s_vss[slot])      vs_n = 1;
      else if (m_h == s_vsp[slot] && m_v == s_vse[slot]) vs_n = 0;
    end else begin
      e_de = 0; e_hs = 0; vs_n = 0;
    end
    e_cs  = (e_hs | vs_n) ^ int'(inv_csync);
    e_hs  = e_hs ^ int'(inv_hsync);
    e_pix = (blank && out_mode == 2'd0) ? int'(BLANK) : int'(pix_i);
    e_fld = (m_run != 0) ? m_fld : 0;
    if (m_run == 0) begin
      load_shadow();
      m_run = 1; m_h = 0; m_v = 0;
    end else if (m_h >= s_ht - 1) begin
      m_h = 0;
      if (m_v >= s_vt[slot] - 1) begin
        m_v = 0;
        m_fld = (cfg_interlace && m_fld == 0) ? 1 : 0;
        load_shadow();
      end else begin
        m_v++;
      end
    end else begin
      m_h++;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R2 data enable", int'(de_o), e_de);
    check("R3 R8 hsync", int'(hsync_o), e_hs);
    check("R4 R8 vsync", int'(vsync_o), vs_n ^ int'(inv_vsync));
    check("R9 R8 csync", int'(csync_o), e_cs);
    check("R5 field flag", int'(field_o), e_fld);
    check("R10 pixel bus", int'(pix_o), e_pix);
    m_vs = vs_n;
  endtask

  task automatic set_mode(input int ha, input int hss, input int hse, input int ht,
                          input int va, input int il,
                          input int ovt, input int ovss, input int ovse, input int ovsp,
                          input int evt, input int evss, input int evse, input int evsp);
    cfg_h_active = ITG_CW'(ha);   cfg_hs_start = ITG_CW'(hss); cfg_hs_end = ITG_CW'(hse);
    cfg_h_total  = ITG_CW'(ht);   cfg_v_active = ITG_CW'(va);  cfg_interlace = il[0];
    cfg_odd_v_total  = ITG_CW'(ovt);  cfg_odd_vs_start  = ITG_CW'(ovss);
    cfg_odd_vs_end   = ITG_CW'(ovse); cfg_odd_vs_pixel  = ITG_CW'(ovsp);
    cfg_even_v_total = ITG_CW'(evt);  cfg_even_vs_start = ITG_CW'(evss);
    cfg_even_vs_end  = ITG_CW'(evse); cfg_even_vs_pixel = ITG_CW'(evsp);
  endtask

  task automatic rand_mode();
    int ht, ha, hss, hse, vt, va, vss, vse, vsp, osp;
    ht  = 10 + int'($urandom % 12);
    ha  = 2 + int'($urandom % (ht - 6));
    hss = ha + 1 + int'($urandom % 2);
    hse = hss + 1 + int'($urandom % (ht - hss - 1));
    vt  = 6 + int'($urandom % 8);
    va  = 2 + int'($urandom % (vt - 4));
    vss = va + 1;
    vse = vss + 1 + int'($urandom % (vt - vss - 1));
    vsp = int'($urandom % ht);
    osp = (hss >= ht/2) ? hss - ht/2 : hss + ht - ht/2;
    set_mode(ha, hss, hse, ht, va, int'($urandom % 2),
             vt + 1, vss + 1, vse + 1, osp, vt, vss, vse, vsp);
  endtask

  // Starts on the first tick of a field whose flag equals lvl; returns on the next field's first tick.
  task automatic run_field(input logic lvl, output int len, output int des);
    len = 1;
    des = int'(de_o);
    for (int k = 0; k < 4000; k++) begin
      tick();
      if (field_o !== lvl) break;
      len++;
      des += int'(de_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed, len, des, highs;
    seed = int'($urandom(32'd7321));
    rst_n = 1'b0;
    inv_hsync = 0; inv_vsync = 0; inv_csync = 0; blank = 0; out_mode = 2'd0;
    pix_i = 24'hABCDEF;
    // scaled interlaced mode: odd field one line longer, mid-line vsync edge
    set_mode(8, 11, 13, 16, 6, 1, 11, 8, 10, 3, 10, 7, 9, 11);
    model_reset();
    load_shadow();
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset hsync", int'(hsync_o), 0);
    check("R1 reset vsync", int'(vsync_o), 0);
    check("R1 reset csync", int'(csync_o), 0);
    check("R1 reset de", int'(de_o), 0);
    check("R1 reset field", int'(field_o), 0);
    check("R1 reset pixel", int'(pix_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // first field after reset is odd (flag low); wait for the even field
    for (int k = 0; k < 2000 && field_o !== 1'b1; k++) tick();
    cfg_h_active = ITG_CW'(5);   // mid-field change, must wait for the next field
    run_field(1'b1, len, des);
    check("R5 even field length", len, 16 * 10);
    check("R7 old width kept for current field", des, 6 * 8);
    run_field(1'b0, len, des);
    check("R5 odd field length", len, 16 * 11);
    check("R7 new width from next field", des, 6 * 5);
    cfg_interlace = 1'b0;         // switch to progressive mid-field
    run_field(1'b1, len, des);
    check("R7 R5 interlace kept for current field", len, 16 * 10);
    highs = 0;
    for (int k = 0; k < 400; k++) begin
      tick();
      highs += int'(field_o);
    end
    check("R6 field flag low in progressive", highs, 0);

    // random modes, polarity, blanking and output mode
    for (int m = 0; m < 12; m++) begin
      rand_mode();
      for (int t = 0; t < 700; t++) begin
        inv_hsync = 1'($urandom % 2);
        inv_vsync = 1'($urandom % 2);
        inv_csync = 1'($urandom % 2);
        blank     = (($urandom % 4) == 0);
        out_mode  = 2'($urandom % 4);
        pix_i     = 24'($urandom);
        tick();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule